// File: doc/BRIEF.md
# Iterative Multiply-Divide Unit with HI/LO Result Registers

This block carries out integer multiplication and division over many clock cycles and keeps the outcome in two dedicated result registers, called HI and LO. A single-cycle start pulse launches one of four operations on two operands: signed multiply, unsigned multiply, signed divide or unsigned divide. Multiplication places the double-width product across the pair, with the upper half in HI and the lower half in LO. Division places the quotient in LO and the remainder in HI. While an operation is running, `busy` stays high. Any pipeline interlock that waits on `busy` is outside this block.

Software can also reach the pair directly. A move-to port loads either register, or both, with a value of its choice, and that value replaces any earlier arithmetic result. A read port selects HI or LO. It flags the read as valid only when the unit is idle, so a reader that waits on that flag is stalled until the running operation has finished.

The datapaths work on operand magnitudes: a shift-add multiplier and a restoring divider. A final cycle then applies the signs before the result is written. Every operation therefore takes the same number of cycles, division by zero included.

Top module: `muldiv_hilo`

## Requirements
- R1: After reset, HI and LO both hold zero and `busy` is low.
- R2: A `start` sampled while `busy` is low is accepted. `busy` is then high for exactly XLEN+1 cycles, and the new HI/LO values are visible in the first cycle in which `busy` is low again.
- R3: Operation code 2'b01 (unsigned multiply) leaves the upper half of the 2*XLEN-bit unsigned product in HI and the lower half in LO.
- R4: Operation code 2'b00 (signed multiply) treats both operands as two's complement and leaves the signed 2*XLEN-bit product split across HI (upper half) and LO (lower half).
- R5: Operation code 2'b11 (unsigned divide) leaves the quotient in LO and the remainder in HI.
- R6: Operation code 2'b10 (signed divide) rounds the quotient toward zero, and the remainder takes the sign of the dividend. The most negative dividend divided by -1 gives LO = most negative value and HI = 0.
- R7: A divide with a zero divisor finishes in the same XLEN+1 busy cycles as any other operation. HI and LO then hold unspecified values.
- R8: A `start` that arrives while `busy` is high is ignored. It neither extends nor restarts the running operation, and it does not change the result.
- R9: While idle, `mt_hi` and `mt_lo` each copy `mt_data` into their register at the next edge, and both may be raised together. While busy, both are ignored, and the register contents seen on `rd_data` do not change.
- R10: `rd_data` shows HI when `rd_sel` is 1 and LO when it is 0. `rd_ok` is high exactly when `rd_req` is high and `busy` is low.
- R11: The result of a completed operation overwrites values written earlier through the move-to port.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Launch pulse for an operation |
| op | input | 2 | 00 signed mul, 01 unsigned mul, 10 signed div, 11 unsigned div |
| src_a | input | XLEN | Multiplicand or dividend |
| src_b | input | XLEN | Multiplier or divisor |
| busy | output | 1 | Operation in progress |
| mt_hi | input | 1 | Write `mt_data` into HI |
| mt_lo | input | 1 | Write `mt_data` into LO |
| mt_data | input | XLEN | Value for the move-to writes |
| rd_req | input | 1 | Read request |
| rd_sel | input | 1 | 1 selects HI, 0 selects LO |
| rd_ok | output | 1 | Read data valid (not stalled) |
| rd_data | output | XLEN | Selected result register |

## Verification
The embedded properties check on every cycle that a launch leads straight into the iteration phase, that the sign-fix cycle always returns the unit to idle, and that a start arriving mid-run never drops `busy`. They also check that HI and LO stay frozen throughout the iterations, that an idle move-to lands its data in the register, and that the divider's partial remainder stays below a nonzero divisor. Only the bench scenarios can show that the finished values are arithmetically right for each signedness and operation, including the most-negative-over-minus-one and all-ones corners. The bench also shows that the busy span is exact and that a completed result displaces earlier move-to data.

// File: rtl/mdu_pkg.sv
`timescale 1ns/1ps
package mdu_pkg;
   typedef enum logic [1:0] {
      OP_MULS = 2'b00,
      OP_MULU = 2'b01,
      OP_DIVS = 2'b10,
      OP_DIVU = 2'b11
   } mdu_op_e;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_RUN  = 2'd1,
      ST_FIN  = 2'd2
   } mdu_st_e;
endpackage

// File: rtl/mdu_seq.sv
`timescale 1ns/1ps
module mdu_seq #(
   parameter int XLEN = 32
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   output logic busy,
   output logic load,
   output logic step,
   output logic fin
);
   import mdu_pkg::*;
   localparam int CW = $clog2(XLEN);

   mdu_st_e       state;
   logic [CW-1:0] cnt;
   logic          last;

   assign last = (cnt == CW'(XLEN - 1));
   assign busy = (state != ST_IDLE);
   assign load = start && (state == ST_IDLE);
   assign step = (state == ST_RUN);
   assign fin  = (state == ST_FIN);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= ST_IDLE;
         cnt   <= '0;
      end else begin
         unique case (state)
            ST_IDLE: if (start) begin
               state <= ST_RUN;
               cnt   <= '0;
            end
            ST_RUN: begin
               cnt <= cnt + CW'(1);
               if (last) state <= ST_FIN;
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   assert_launch_R2: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> (step && cnt == '0));
   assert_release_R2: assert property (@(posedge clk) disable iff (!rst_n)
      fin |=> !busy);
   assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (step && start) |=> busy);
endmodule

// File: rtl/mdu_mul_core.sv
`timescale 1ns/1ps
module mdu_mul_core #(
   parameter int XLEN = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic              step,
   input  logic [XLEN-1:0]   mcand_in,
   input  logic [XLEN-1:0]   mplier_in,
   output logic [2*XLEN-1:0] prod
);
   logic [XLEN-1:0] acc, mpl, mcd;
   logic [XLEN:0]   sum;

   assign sum  = {1'b0, acc} + (mpl[0] ? {1'b0, mcd} : '0);
   assign prod = {acc, mpl};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc <= '0;
         mpl <= '0;
         mcd <= '0;
      end else if (load) begin
         acc <= '0;
         mpl <= mplier_in;
         mcd <= mcand_in;
      end else if (step) begin
         acc <= sum[XLEN:1];
         mpl <= {sum[0], mpl[XLEN-1:1]};
      end
   end

   assert_zero_mcand_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (step && mcd == '0 && acc == '0) |=> acc == '0);
endmodule

// File: rtl/mdu_div_core.sv
`timescale 1ns/1ps
module mdu_div_core #(
   parameter int XLEN = 32
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            load,
   input  logic            step,
   input  logic [XLEN-1:0] dvd_in,
   input  logic [XLEN-1:0] dvs_in,
   output logic [XLEN-1:0] quo,
   output logic [XLEN-1:0] rem
);
   logic [XLEN-1:0] dvs;
   logic [XLEN-1:0] shifted, diff;
   logic            fits;

   assign shifted = {rem[XLEN-2:0], quo[XLEN-1]};
   assign fits    = {rem, quo[XLEN-1]} >= {1'b0, dvs};
   assign diff    = shifted - dvs;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         quo <= '0;
         rem <= '0;
         dvs <= '0;
      end else if (load) begin
         quo <= dvd_in;
         rem <= '0;
         dvs <= dvs_in;
      end else if (step) begin
         rem <= fits ? diff : shifted;
         quo <= {quo[XLEN-2:0], fits};
      end
   end

   assert_rem_below_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (dvs != '0) |-> (rem < dvs));
endmodule

// File: rtl/muldiv_hilo.sv
`timescale 1ns/1ps
module muldiv_hilo #(
   parameter int XLEN = 32
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            start,
   input  logic [1:0]      op,
   input  logic [XLEN-1:0] src_a,
   input  logic [XLEN-1:0] src_b,
   output logic            busy,
   input  logic            mt_hi,
   input  logic            mt_lo,
   input  logic [XLEN-1:0] mt_data,
   input  logic            rd_req,
   input  logic            rd_sel,
   output logic            rd_ok,
   output logic [XLEN-1:0] rd_data
);
   import mdu_pkg::*;

   generate
      if (XLEN < 4) begin : g_bad_width
         $error("muldiv_hilo: XLEN must be at least 4");
      end
   endgenerate

   logic              load, step, fin;
   logic              is_signed, a_neg, b_neg;
   logic [XLEN-1:0]   mag_a, mag_b;
   logic              div_q, negp_q, negr_q;
   logic [2*XLEN-1:0] prod, prod_fix;
   logic [XLEN-1:0]   quo, rem;
   logic [XLEN-1:0]   res_hi, res_lo;
   logic [XLEN-1:0]   hi_q, lo_q;

   mdu_seq #(.XLEN(XLEN)) u_seq (
      .clk(clk), .rst_n(rst_n), .start(start),
      .busy(busy), .load(load), .step(step), .fin(fin)
   );

   assign is_signed = (op == OP_MULS) || (op == OP_DIVS);
   assign a_neg     = is_signed && src_a[XLEN-1];
   assign b_neg     = is_signed && src_b[XLEN-1];
   assign mag_a     = a_neg ? (~src_a + XLEN'(1)) : src_a;
   assign mag_b     = b_neg ? (~src_b + XLEN'(1)) : src_b;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         div_q  <= 1'b0;
         negp_q <= 1'b0;
         negr_q <= 1'b0;
      end else if (load) begin
         div_q  <= op[1];
         negp_q <= a_neg ^ b_neg;
         negr_q <= a_neg;
      end
   end

   mdu_mul_core #(.XLEN(XLEN)) u_mul (
      .clk(clk), .rst_n(rst_n), .load(load), .step(step && !div_q),
      .mcand_in(mag_a), .mplier_in(mag_b), .prod(prod)
   );

   mdu_div_core #(.XLEN(XLEN)) u_div (
      .clk(clk), .rst_n(rst_n), .load(load), .step(step && div_q),
      .dvd_in(mag_a), .dvs_in(mag_b), .quo(quo), .rem(rem)
   );

   assign prod_fix = negp_q ? (~prod + (2*XLEN)'(1)) : prod;

   always_comb begin
      if (div_q) begin
         res_lo = negp_q ? (~quo + XLEN'(1)) : quo;
         res_hi = negr_q ? (~rem + XLEN'(1)) : rem;
      end else begin
         res_lo = prod_fix[XLEN-1:0];
         res_hi = prod_fix[2*XLEN-1:XLEN];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hi_q <= '0;
         lo_q <= '0;
      end else if (fin) begin
         hi_q <= res_hi;
         lo_q <= res_lo;
      end else if (!busy) begin
         if (mt_hi) hi_q <= mt_data;
         if (mt_lo) lo_q <= mt_data;
      end
   end

   assign rd_ok   = rd_req && !busy;
   assign rd_data = rd_sel ? hi_q : lo_q;

   assert_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !fin) |=> ($stable(hi_q) && $stable(lo_q)));
   assert_mt_hi_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && mt_hi) |=> (hi_q == $past(mt_data)));
   assert_mt_lo_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && mt_lo) |=> (lo_q == $past(mt_data)));
endmodule

// File: tb/sim_muldiv_hilo.sv
`timescale 1ns/1ps
module sim_muldiv_hilo;
   localparam int XLEN = 32;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            start = 1'b0;
   logic [1:0]      op = 2'b00;
   logic [XLEN-1:0] src_a = '0, src_b = '0;
   logic            busy;
   logic            mt_hi = 1'b0, mt_lo = 1'b0;
   logic [XLEN-1:0] mt_data = '0;
   logic            rd_req = 1'b0, rd_sel = 1'b0;
   logic            rd_ok;
   logic [XLEN-1:0] rd_data;

   int nchk = 0, nfail = 0;
   string cur = "R1", btag = "R2";

   // reference model state
   int              busy_cnt = 0;
   logic [XLEN-1:0] m_hi = '0, m_lo = '0, p_hi = '0, p_lo = '0;
   bit              hi_k = 1'b1, lo_k = 1'b1, p_k = 1'b1;

   always #2 clk = ~clk;

   muldiv_hilo #(.XLEN(XLEN)) u0 (
      .clk(clk), .rst_n(rst_n), .start(start), .op(op),
      .src_a(src_a), .src_b(src_b), .busy(busy),
      .mt_hi(mt_hi), .mt_lo(mt_lo), .mt_data(mt_data),
      .rd_req(rd_req), .rd_sel(rd_sel), .rd_ok(rd_ok), .rd_data(rd_data)
   );

   task automatic chk(input bit ok, input string req,
                      input logic [XLEN-1:0] act, input logic [XLEN-1:0] exp);
      nchk++;
      if (!ok) begin
         nfail++;
         $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
      end
   endtask

   task automatic compute(input logic [1:0] o, input logic [XLEN-1:0] a,
                          input logic [XLEN-1:0] b);
      logic [63:0] pu;
      longint      x, y, q, r;
      p_k = 1'b1;
      case (o)
         2'b01: begin pu = {32'h0, a} * {32'h0, b}; p_hi = pu[63:32]; p_lo = pu[31:0]; end
         2'b00: begin
            x = longint'($signed(a)); y = longint'($signed(b)); pu = 64'(x * y);
            p_hi = pu[63:32]; p_lo = pu[31:0];
         end
         2'b11: if (b == 0) p_k = 1'b0; else begin p_lo = a / b; p_hi = a % b; end
         default: if (b == 0) p_k = 1'b0; else begin
            x = longint'($signed(a)); y = longint'($signed(b));
            q = x / y; r = x % y;
            p_lo = q[31:0]; p_hi = r[31:0];
         end
      endcase
   endtask

   always @(negedge clk) begin
      if (rst_n) begin
         chk(busy == (busy_cnt > 0), btag, {31'b0, busy}, {31'b0, busy_cnt > 0});
         chk(rd_ok == (rd_req && busy_cnt == 0), "R10", {31'b0, rd_ok},
             {31'b0, rd_req && busy_cnt == 0});
         if (rd_sel ? hi_k : lo_k)
            chk(rd_data == (rd_sel ? m_hi : m_lo), cur, rd_data, rd_sel ? m_hi : m_lo);
      end
      if (!rst_n) begin
         busy_cnt = 0; m_hi = '0; m_lo = '0; hi_k = 1'b1; lo_k = 1'b1;
      end else if (busy_cnt > 0) begin
         busy_cnt--;
         if (busy_cnt == 0) begin
            m_hi = p_hi; m_lo = p_lo; hi_k = p_k; lo_k = p_k;
         end
      end else begin
         if (mt_hi) begin m_hi = mt_data; hi_k = 1'b1; end
         if (mt_lo) begin m_lo = mt_data; lo_k = 1'b1; end
         if (start) begin compute(op, src_a, src_b); busy_cnt = XLEN + 1; end
      end
   end

   task automatic tick();
      @(posedge clk); #1;
   endtask

   task automatic move_to(input bit h, input bit l, input logic [XLEN-1:0] d);
      mt_hi = h; mt_lo = l; mt_data = d;
      tick();
      mt_hi = 1'b0; mt_lo = 1'b0;
      rd_sel = 1'b0; tick(); rd_sel = 1'b1; tick();
   endtask

   task automatic run_op(input logic [1:0] o, input logic [XLEN-1:0] a,
                         input logic [XLEN-1:0] b, input bit inject);
      op = o; src_a = a; src_b = b; start = 1'b1;
      tick();
      start = 1'b0;
      repeat (4) tick();
      if (inject) begin
         start = 1'b1; op = ~o; src_a = 32'h0BAD_F00D; src_b = 32'h3;
         mt_hi = 1'b1; mt_lo = 1'b1; mt_data = 32'hDEAD_BEEF;
         tick();
         start = 1'b0; mt_hi = 1'b0; mt_lo = 1'b0;
         rd_sel = 1'b0; tick(); rd_sel = 1'b1; tick();
      end
      while (busy) tick();
      rd_sel = 1'b0; tick(); rd_sel = 1'b1; tick();
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      nfail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
   end

   initial begin
      repeat (3) tick();
      rst_n = 1'b1;
      cur = "R1";
      rd_sel = 1'b0; tick(); rd_sel = 1'b1; tick();

      cur = "R9";
      move_to(1'b1, 1'b1, 32'h1234_5678);
      move_to(1'b0, 1'b1, 32'hCAFE_0001);

      cur = "R3";
      run_op(2'b01, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b0);
      run_op(2'b01, 32'h1234_5678, 32'h9ABC_DEF0, 1'b0);

      cur = "R4";
      run_op(2'b00, 32'hFFFF_FFFD, 32'd7, 1'b0);
      run_op(2'b00, 32'h8000_0000, 32'h8000_0000, 1'b0);
      run_op(2'b00, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b0);
      run_op(2'b00, 32'd12345, 32'hFFFF_0000, 1'b0);

      cur = "R5";
      run_op(2'b11, 32'd100, 32'd7, 1'b0);
      run_op(2'b11, 32'hFFFF_FFFF, 32'h10, 1'b0);
      run_op(2'b11, 32'd5, 32'd9, 1'b0);

      cur = "R6";
      run_op(2'b10, 32'hFFFF_FFF9, 32'd2, 1'b0);
      run_op(2'b10, 32'd7, 32'hFFFF_FFFE, 1'b0);
      run_op(2'b10, 32'h8000_0000, 32'hFFFF_FFFF, 1'b0);
      run_op(2'b10, 32'hFFFF_FF00, 32'hFFFF_FFF0, 1'b0);

      cur = "R7"; btag = "R7";
      run_op(2'b11, 32'd77, 32'd0, 1'b0);
      run_op(2'b10, 32'hFFFF_FFF0, 32'd0, 1'b0);
      cur = "R9"; btag = "R2";
      move_to(1'b1, 1'b1, 32'h0F0F_0F0F);

      cur = "R8"; btag = "R8";
      run_op(2'b01, 32'd1000, 32'd3000, 1'b1);
      run_op(2'b11, 32'd1000, 32'd3, 1'b1);
      btag = "R2";

      cur = "R11";
      move_to(1'b1, 1'b1, 32'hAAAA_5555);
      run_op(2'b01, 32'd6, 32'd7, 1'b0);

      cur = "R10";
      rd_req = 1'b1;
      run_op(2'b00, 32'h7FFF_FFFF, 32'h7FFF_FFFF, 1'b0);
      rd_req = 1'b0;
      tick();

      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
   end
endmodule